// File: doc/BRIEF.md
# 4:1:1 YUV Input Demultiplexer

This block takes a time-multiplexed 4:1:1 video stream and turns it into whole pixel groups. Each input clock brings one 8-bit luminance sample on the luma bus and four chroma bits on the chroma bus. Four consecutive clocks make one group: four luminance samples, one U byte and one V byte. The U and V bytes arrive two bits per clock, most significant pair first.

A data window input aligns the groups. The first clock on which the window is high is phase 0 of a group. While the window stays high, phases 0..3 repeat back to back. When the window drops, any group that is not yet complete is thrown away. After phase 3 has been sampled, the block presents the four luminance bytes and the assembled U and V bytes, with a one-cycle valid strobe. U and V are two's-complement values, and a chroma-invert input can complement them bit for bit. Luminance is straight binary and passes through unchanged.

Top module: `yuv411_demux`

## Requirements
- R1: While rst_ni is low, and on the first clock after it is released, valid_o is 0 and y_o, u_o and v_o are all 0.
- R2: Samples taken while win_i is low are ignored. The first clock with win_i high after one or more low clocks is phase 0, and each later high clock advances the phase by one, wrapping from 3 to 0.
- R3: y_o byte k (bits 8k+7:8k) holds the luma_i sample taken in phase k, so the byte for phase 0 is in y_o[7:0].
- R4: On every phase, chroma_i[3:2] carries two U bits and chroma_i[1:0] carries two V bits. Phase 0 carries bits 7:6, phase 1 bits 5:4, phase 2 bits 3:2 and phase 3 bits 1:0. Within each pair, the higher pin is the higher bit.
- R5: valid_o is high for exactly one cycle: the cycle after the clock on which phase 3 is sampled. With win_i held high, strobes come every 4 cycles.
- R6: If uv_inv_i is high on the clock that samples phase 3, then u_o and v_o are the bitwise complement of the assembled bytes. y_o is never affected by uv_inv_i.
- R7: If win_i falls before phase 3 has been sampled, the group produces no strobe, and y_o, u_o and v_o keep their previous values.
- R8: y_o, u_o and v_o change only on the cycle where valid_o is high, and hold their values at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_i | input | 1 | Data window; its rising edge marks phase 0 |
| luma_i | input | 8 | Luminance sample, straight binary |
| chroma_i | input | 4 | Chroma bits: [3:2] U pair, [1:0] V pair |
| uv_inv_i | input | 1 | Complement U and V of the current group |
| valid_o | output | 1 | One-cycle strobe: a new group is on the outputs |
| y_o | output | 32 | Four luma bytes, phase 0 in the low byte |
| u_o | output | 8 | Assembled U byte |
| v_o | output | 8 | Assembled V byte |

## Verification
The assertions assume that win_i, luma_i, chroma_i and uv_inv_i change only away from the rising clock edge, and that they hold known values once reset is released. Nothing is assumed about when win_i rises or falls, so a window may last any number of clocks. The bench drives every input on the falling edge. It holds win_i low through reset, and it opens and closes windows both on group boundaries and in the middle of a group.

// File: rtl/yuv411_pkg.sv
package yuv411_pkg;
  localparam int unsigned LUMA_W   = 8;
  localparam int unsigned CHROMA_W = 8;
  localparam int unsigned PHASES   = 4;
  localparam int unsigned PAIR_W   = CHROMA_W / PHASES;
  localparam int unsigned PIN_W    = 2 * PAIR_W;
  localparam int unsigned PH_W     = $clog2(PHASES);
endpackage

// File: rtl/yuv411_phase_ctr.sv
module yuv411_phase_ctr
  import yuv411_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            win_i,
  output logic [PH_W-1:0] phase_o,
  output logic            last_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

  logic [PH_W-1:0] cnt_q;

  // cnt_q is the phase of the sample on the current clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!win_i)               cnt_q <= '0;
    else if (cnt_q == LAST)        cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  assign phase_o = cnt_q;
  assign last_o  = win_i && (cnt_q == LAST);

  // R2: a closed window restarts the group at phase 0
  a_r2_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_i |=> cnt_q == '0);
  // R2: inside a window the phase advances and does not drop back early
  a_r2_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_i && cnt_q != LAST) |=> cnt_q != '0);
endmodule

// File: rtl/yuv411_chroma_asm.sv
module yuv411_chroma_asm
  import yuv411_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                take_i,
  input  logic                first_i,
  input  logic [PAIR_W-1:0]   pair_i,
  output logic [CHROMA_W-1:0] word_o
);
  logic [CHROMA_W-PAIR_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (take_i)
      acc_q <= first_i ? {{(CHROMA_W-2*PAIR_W){1'b0}}, pair_i}
                       : {acc_q[CHROMA_W-2*PAIR_W-1:0], pair_i};
  end

  // MSB pair first; the final pair completes the word combinationally
  assign word_o = {acc_q, pair_i};
endmodule

// File: rtl/yuv411_luma_gather.sv
module yuv411_luma_gather
  import yuv411_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     take_i,
  input  logic [PH_W-1:0]          phase_i,
  input  logic [LUMA_W-1:0]        luma_i,
  output logic [PHASES*LUMA_W-1:0] group_o
);
  logic [LUMA_W-1:0] slot_q [PHASES-1];

  for (genvar k = 0; k < PHASES - 1; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              slot_q[k] <= '0;
      else if (take_i && phase_i == PH_W'(k))   slot_q[k] <= luma_i;
    end
    assign group_o[k*LUMA_W +: LUMA_W] = slot_q[k];
  end

  assign group_o[(PHASES-1)*LUMA_W +: LUMA_W] = luma_i;
endmodule

// File: rtl/yuv411_demux.sv
module yuv411_demux
  import yuv411_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     win_i,
  input  logic [LUMA_W-1:0]        luma_i,
  input  logic [PIN_W-1:0]         chroma_i,
  input  logic                     uv_inv_i,
  output logic                     valid_o,
  output logic [PHASES*LUMA_W-1:0] y_o,
  output logic [CHROMA_W-1:0]      u_o,
  output logic [CHROMA_W-1:0]      v_o
);
  logic [PH_W-1:0]          phase;
  logic                     last;
  logic [PHASES*LUMA_W-1:0] y_grp;
  logic [CHROMA_W-1:0]      u_word, v_word;
  logic [CHROMA_W-1:0]      inv_mask;

  yuv411_phase_ctr u_phase (
    .clk_i, .rst_ni, .win_i, .phase_o(phase), .last_o(last)
  );

  yuv411_luma_gather u_luma (
    .clk_i, .rst_ni, .take_i(win_i), .phase_i(phase),
    .luma_i, .group_o(y_grp)
  );

  // U on the upper pin pair, V on the lower
  yuv411_chroma_asm u_cu (
    .clk_i, .rst_ni, .take_i(win_i), .first_i(phase == '0),
    .pair_i(chroma_i[PIN_W-1 -: PAIR_W]), .word_o(u_word)
  );
  yuv411_chroma_asm u_cv (
    .clk_i, .rst_ni, .take_i(win_i), .first_i(phase == '0),
    .pair_i(chroma_i[PAIR_W-1:0]), .word_o(v_word)
  );

  assign inv_mask = {CHROMA_W{uv_inv_i}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      y_o     <= '0;
      u_o     <= '0;
      v_o     <= '0;
    end else begin
      valid_o <= last;
      if (last) begin
        y_o <= y_grp;
        u_o <= u_word ^ inv_mask;
        v_o <= v_word ^ inv_mask;
      end
    end
  end

  // R5: strobe lasts a single cycle
  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R7: no strobe unless the previous clock was inside the window
  a_r7_needs_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(win_i));
  // R8: outputs hold between strobes
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(y_o) && $stable(u_o) && $stable(v_o)));
  // R2: a strobe needs four consecutive window clocks
  a_r2_full_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(win_i, 2) && $past(win_i, 3) && $past(win_i, 4)));
endmodule

// File: tb/yuv411_demux_test.sv
module yuv411_demux_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win = 1'b0;
  logic [7:0]  luma = '0;
  logic [3:0]  chroma = '0;
  logic        uv_inv = 1'b0;
  logic        valid;
  logic [31:0] y;
  logic [7:0]  u, v;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_y = '0;
  logic [7:0]  exp_u = '0, exp_v = '0;

  always #10 clk = ~clk;

  yuv411_demux uut (
    .clk_i(clk), .rst_ni(rst_n), .win_i(win), .luma_i(luma),
    .chroma_i(chroma), .uv_inv_i(uv_inv), .valid_o(valid),
    .y_o(y), .u_o(u), .v_o(v)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic vexp);
    chk(req, {63'd0, valid}, {63'd0, vexp});
    chk(req, {16'd0, y, u, v}, {16'd0, exp_y, exp_u, exp_v});
  endtask

  // drive one phase at the negedge, sample mid-high after the edge
  task automatic step(input logic w, input logic [7:0] l, input logic [3:0] c, input logic inv);
    @(negedge clk);
    win = w; luma = l; chroma = c; uv_inv = inv;
    @(posedge clk); #5;
  endtask

  // full group; checks are made in the cycle after phase 3
  task automatic group(input string req, input logic [31:0] yy, input logic [7:0] uu,
                       input logic [7:0] vv, input logic inv);
    for (int p = 0; p < 4; p++) begin
      step(1'b1, yy[8*p +: 8], {uu[7-2*p -: 2], vv[7-2*p -: 2]}, inv);
      if (p < 3) chk_out({req, " mid-group"}, 1'b0);
    end
    exp_y = yy;
    exp_u = inv ? ~uu : uu;
    exp_v = inv ? ~vv : vv;
    chk_out(req, 1'b1);
  endtask

  task automatic t_reset;
    #5 chk_out("R1 in reset", 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #5;
    chk_out("R1 after release", 1'b0);
  endtask

  task automatic t_idle;
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 8'hA5 + 8'(i), 4'hF, 1'b1);
      chk_out("R2 window low ignored", 1'b0);
    end
  endtask

  task automatic t_basic;
    group("R3 R4 R5 first group", 32'h44332211, 8'hC9, 8'h36, 1'b0);
    step(1'b0, 8'h00, 4'h0, 1'b0);
    chk_out("R5 strobe one cycle", 1'b0);
  endtask

  task automatic t_back_to_back;
    group("R5 back-to-back a", 32'hDEADBEEF, 8'h80, 8'h7F, 1'b0);
    group("R5 back-to-back b", 32'h01020304, 8'h1B, 8'hE4, 1'b0);
    group("R5 back-to-back c", 32'hFF00FF00, 8'hFF, 8'h00, 1'b0);
    step(1'b0, 8'h00, 4'h0, 1'b0);
  endtask

  task automatic t_invert;
    group("R6 invert", 32'h76543210, 8'h5A, 8'h3C, 1'b1);
    step(1'b0, 8'h00, 4'h0, 1'b0);
    group("R6 no invert", 32'h89ABCDEF, 8'h5A, 8'h3C, 1'b0);
    step(1'b0, 8'h00, 4'h0, 1'b0);
  endtask

  task automatic t_truncate;
    for (int n = 1; n < 4; n++) begin
      for (int p = 0; p < n; p++) begin
        step(1'b1, 8'h60 + 8'(p), 4'hA, 1'b0);
        chk_out("R7 partial group", 1'b0);
      end
      step(1'b0, 8'h00, 4'h5, 1'b0);
      chk_out("R7 discarded", 1'b0);
      step(1'b0, 8'h00, 4'h5, 1'b0);
      chk_out("R8 hold after discard", 1'b0);
    end
    // realignment: next window starts at phase 0
    group("R2 realign after truncation", 32'hCAFEF00D, 8'h96, 8'h69, 1'b0);
    step(1'b0, 8'h00, 4'h0, 1'b0);
  endtask

  task automatic t_hold;
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 8'(i * 37), 4'(i), i[0]);
      chk_out("R8 hold idle", 1'b0);
    end
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_idle();
        t_basic();
        t_back_to_back();
        t_invert();
        t_truncate();
        t_hold();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule